// File: doc/BRIEF.md
# Multi-Format Floating-Point Equality Comparator

This block decides whether two IEEE-754 operands are equal and reports the exception flags that a quiet equality compare raises. A two-bit format code picks half (16-bit), single (32-bit) or double (64-bit) precision. The operands always arrive on 64-bit inputs. A narrower value occupies the low bits of its input, and the bits above it play no part in the result.

The block is purely combinational. It sorts each operand as not-NaN, quiet NaN or signaling NaN. It compares the bit patterns and lets a positive zero equal a negative zero. The result appears as a single bit and as the same bit zero-extended to a register-width word, ready for an integer write-back. The five-bit flag vector feeds an accumulator elsewhere in the pipeline.

Top module: `fp_eq_cmp`

## Requirements
- R1: `fmt_i` selects the format: 0 = half (exponent 5 bits, fraction 10 bits), 1 = single (8/23), 2 = double (11/52), 3 = treated exactly as double. The operand's sign is bit width-1 of its input, and its fraction is in the low bits.
- R2: For half and single formats, input bits at and above the format width (16 or 32) have no effect on any output.
- R3: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. An infinity (exponent all ones, fraction zero) is not a NaN, and two identical infinities compare equal.
- R4: A quiet NaN (top fraction bit 1) on either operand forces `eq_o` to 0. When neither operand is a signaling NaN, the flags stay at zero.
- R5: A signaling NaN (top fraction bit 0, fraction nonzero) on either operand drives `flags_o` to exactly 5'b10000 and `eq_o` to 0.
- R6: `flags_o` is ordered invalid, divide-by-zero, overflow, underflow, inexact from bit 4 down to bit 0. Bits 3..0 are always 0, and bit 4 is 0 unless R5 applies.
- R7: When neither operand is a NaN and both have identical bit patterns in the selected width, `eq_o` is 1. This includes subnormals.
- R8: When both operands have all-zero exponent and fraction, `eq_o` is 1 whatever their signs are.
- R9: In every other case `eq_o` is 0. Examples are +1 against -1, a subnormal against zero, and +inf against -inf.
- R10: `result_o` equals `eq_o` in bit 0, with every higher bit 0.
- R11: The outputs depend only on the present inputs, with no clock, state or latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_i | input | 2 | Format code (0 half, 1 single, 2/3 double) |
| op_a_i | input | 64 | First operand, right-aligned |
| op_b_i | input | 64 | Second operand, right-aligned |
| eq_o | output | 1 | Equality result |
| result_o | output | XLEN | Zero-extended equality result |
| flags_o | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
Every format gets both signs of zero. These show that the sign-discard rule applies and that it applies only to zeros: the bench also checks +1 against -1 and a subnormal against zero. Equal and unequal normals, identical subnormals and both signs of infinity show the boundary between the infinity and NaN encodings. Every pairing of quiet NaN, signaling NaN and an ordinary number, in both operand positions, shows that invalid is raised only by the signaling kind. Half and single operands are also sent with random bits above their width, and the reserved format code is compared against the double result. A behavioural reference model checks all of these cases and a stream of random vectors.

// File: rtl/fp_eq_pkg.sv
package fp_eq_pkg;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_RSVD   = 2'd3
  } fp_fmt_e;

  localparam int NUM_FMT = 3;
  localparam int OP_W    = 64;
  localparam int FLAG_W  = 5;

  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic uf;
    logic nx;
  } fp_flags_t;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int fmt_width(input int idx);
    return 1 + fmt_exp_w(idx) + fmt_man_w(idx);
  endfunction

endpackage

// File: rtl/fp_nan_detect.sv
module fp_nan_detect #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W-1:0] mag_i,
  output logic             is_nan_o,
  output logic             is_snan_o,
  output logic             is_zero_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;

  assign exp_f   = mag_i[MAG_W-1:MAN_W];
  assign man_f   = mag_i[MAN_W-1:0];
  assign exp_max = &exp_f;

  assign is_nan_o  = exp_max & (|man_f);
  // top fraction bit clear marks signaling
  assign is_snan_o = is_nan_o & ~man_f[MAN_W-1];
  assign is_zero_o = ~(|mag_i);

endmodule

// File: rtl/fp_eq_lane.sv
module fp_eq_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o,
  output logic         invalid_o
);

  logic nan_a, snan_a, zero_a;
  logic nan_b, snan_b, zero_b;

  fp_nan_detect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_det_a (
    .mag_i    (a_i[W-2:0]),
    .is_nan_o (nan_a),
    .is_snan_o(snan_a),
    .is_zero_o(zero_a)
  );

  fp_nan_detect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_det_b (
    .mag_i    (b_i[W-2:0]),
    .is_nan_o (nan_b),
    .is_snan_o(snan_b),
    .is_zero_o(zero_b)
  );

  logic same_bits;
  assign same_bits = (a_i == b_i);

  assign eq_o      = (~nan_a & ~nan_b & same_bits) | (zero_a & zero_b);
  assign invalid_o = snan_a | snan_b;

endmodule

// File: rtl/fp_eq_cmp.sv
module fp_eq_cmp
  import fp_eq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]        fmt_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic              eq_o,
  output logic [XLEN-1:0]   result_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [NUM_FMT-1:0] lane_eq;
  logic [NUM_FMT-1:0] lane_inv;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int EW = fmt_exp_w(g);
    localparam int MW = fmt_man_w(g);
    localparam int LW = 1 + EW + MW;

    fp_eq_lane #(.EXP_W(EW), .MAN_W(MW)) u_lane (
      .a_i      (op_a_i[LW-1:0]),
      .b_i      (op_b_i[LW-1:0]),
      .eq_o     (lane_eq[g]),
      .invalid_o(lane_inv[g])
    );
  end

  fp_fmt_e   fmt_sel;
  logic      eq_sel;
  logic      inv_sel;
  fp_flags_t flags_s;

  assign fmt_sel = fp_fmt_e'(fmt_i);

  always_comb begin
    case (fmt_sel)
      FMT_HALF:   begin eq_sel = lane_eq[0]; inv_sel = lane_inv[0]; end
      FMT_SINGLE: begin eq_sel = lane_eq[1]; inv_sel = lane_inv[1]; end
      default:    begin eq_sel = lane_eq[2]; inv_sel = lane_inv[2]; end
    endcase
  end

  always_comb begin
    flags_s    = '0;
    flags_s.nv = inv_sel;
  end

  assign eq_o     = eq_sel;
  assign flags_o  = flags_s;
  assign result_o = {{(XLEN-1){1'b0}}, eq_sel};

endmodule

// File: rtl/fp_eq_cmp_chk.sv
module fp_eq_cmp_chk
  import fp_eq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic [1:0]        fmt_i,
  input logic [OP_W-1:0]   op_a_i,
  input logic [OP_W-1:0]   op_b_i,
  input logic              eq_o,
  input logic [XLEN-1:0]   result_o,
  input logic [FLAG_W-1:0] flags_o
);

  logic [OP_W-1:0] a_m, b_m, mag_mask;
  logic            a_expmax;

  always_comb begin
    case (fmt_i)
      2'd0: begin
        a_m = {48'd0, op_a_i[15:0]}; b_m = {48'd0, op_b_i[15:0]};
        mag_mask = 64'h0000_0000_0000_7fff;
        a_expmax = &op_a_i[14:10];
      end
      2'd1: begin
        a_m = {32'd0, op_a_i[31:0]}; b_m = {32'd0, op_b_i[31:0]};
        mag_mask = 64'h0000_0000_7fff_ffff;
        a_expmax = &op_a_i[30:23];
      end
      default: begin
        a_m = op_a_i; b_m = op_b_i;
        mag_mask = 64'h7fff_ffff_ffff_ffff;
        a_expmax = &op_a_i[62:52];
      end
    endcase
  end

  always_comb begin
    // R6
    flag_low_zero_chk: assert (flags_o[3:0] == 4'd0);
    // R5
    nv_blocks_eq_chk: assert (!(flags_o[4] && eq_o));
    // R10
    result_ext_chk: assert ((result_o[0] == eq_o) && ($countones(result_o) <= 1));
    // R8
    zero_pair_chk: assert (!(((a_m | b_m) & mag_mask) == 64'd0) || eq_o);
    // R7
    same_num_chk: assert (!((a_m == b_m) && !a_expmax) || eq_o);
    // R9
    eq_needs_match_chk: assert (!eq_o || (a_m == b_m) || (((a_m | b_m) & mag_mask) == 64'd0));
  end

endmodule

bind fp_eq_cmp fp_eq_cmp_chk #(.XLEN(XLEN)) u_chk (
  .fmt_i   (fmt_i),
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .eq_o    (eq_o),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/fp_eq_cmp_bench.sv
module fp_eq_cmp_bench;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]      fmt_i = 2'd0;
  logic [63:0]     op_a_i = '0, op_b_i = '0;
  logic            eq_o;
  logic [XLEN-1:0] result_o;
  logic [4:0]      flags_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fp_eq_cmp #(.XLEN(XLEN)) u_fp_eq_cmp (
    .fmt_i(fmt_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .eq_o(eq_o), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic void fmt_par(input int f, output int ew, output int mw);
    case (f)
      0: begin ew = 5;  mw = 10; end
      1: begin ew = 8;  mw = 23; end
      default: begin ew = 11; mw = 52; end
    endcase
  endfunction

  function automatic logic [63:0] mk(input int f, input bit s, input longint unsigned e,
                                     input longint unsigned m);
    int ew, mw;
    fmt_par(f, ew, mw);
    return ({63'd0, s} << (ew + mw)) | (e << mw) | m;
  endfunction

  function automatic void ref_model(input int f, input logic [63:0] a, input logic [63:0] b,
                                    output bit eq, output bit [4:0] fl);
    int ew, mw, w;
    longint unsigned msk, av, bv, emax, ea, eb, ma, mb;
    bit na, nb, sa, sb;
    fmt_par(f, ew, mw);
    w = 1 + ew + mw;
    msk = (w == 64) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << w) - 1);
    av = a & msk; bv = b & msk;
    emax = (64'd1 << ew) - 1;
    ea = (av >> mw) & emax; eb = (bv >> mw) & emax;
    ma = av & ((64'd1 << mw) - 1); mb = bv & ((64'd1 << mw) - 1);
    na = (ea == emax) && (ma != 0);
    nb = (eb == emax) && (mb != 0);
    sa = na && (((ma >> (mw - 1)) & 1) == 0);
    sb = nb && (((mb >> (mw - 1)) & 1) == 0);
    eq = (!na && !nb && av == bv) || (((av | bv) & (msk >> 1)) == 0);
    fl = (sa || sb) ? 5'b10000 : 5'b00000;
  endfunction

  task automatic run(input int f, input logic [63:0] a, input logic [63:0] b, input string tag);
    bit ex_eq;
    bit [4:0] ex_fl;
    logic [XLEN-1:0] ex_res;
    @(posedge clk);
    #1;
    fmt_i = f[1:0]; op_a_i = a; op_b_i = b;
    ref_model(f, a, b, ex_eq, ex_fl);
    ex_res = '0; ex_res[0] = ex_eq;
    @(negedge clk);
    n_chk++;
    if (eq_o !== ex_eq || flags_o !== ex_fl || result_o !== ex_res) begin
      n_fail++;
      $display("FAIL %s fmt=%0d a=%h b=%h: actual eq=%b flags=%b res=%h expected eq=%b flags=%b res=%h",
               tag, f, a, b, eq_o, flags_o, result_o, ex_eq, ex_fl, ex_res);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    // reset-time state: zero operands compare equal (R8, R10)
    @(negedge clk);
    n_chk++;
    if (eq_o !== 1'b1 || flags_o !== 5'd0 || result_o !== 64'd1) begin
      n_fail++;
      $display("FAIL R8 reset: actual eq=%b flags=%b expected eq=1 flags=00000", eq_o, flags_o);
    end
    rst_ni = 1'b1;

    for (int f = 0; f < 3; f++) begin
      int ew, mw;
      longint unsigned em, bias, qm, sm;
      fmt_par(f, ew, mw);
      em = (64'd1 << ew) - 1; bias = (64'd1 << (ew - 1)) - 1;
      qm = 64'd1 << (mw - 1); sm = 64'd1;
      run(f, mk(f,0,0,0),    mk(f,1,0,0),    "R8 +0/-0");
      run(f, mk(f,1,0,0),    mk(f,1,0,0),    "R8 -0/-0");
      run(f, mk(f,0,bias,0), mk(f,0,bias,0), "R7 1/1");
      run(f, mk(f,0,bias,5), mk(f,0,bias,5), "R1 fraction bits");
      run(f, mk(f,0,bias,0), mk(f,1,bias,0), "R9 1/-1");
      run(f, mk(f,0,bias,0), mk(f,0,bias+1,0), "R9 1/2");
      run(f, mk(f,0,0,1),    mk(f,0,0,1),    "R7 subnormal");
      run(f, mk(f,0,0,1),    mk(f,0,0,0),    "R9 subnormal/zero");
      run(f, mk(f,0,em,0),   mk(f,0,em,0),   "R3 inf/inf");
      run(f, mk(f,0,em,0),   mk(f,1,em,0),   "R9 inf/-inf");
      run(f, mk(f,0,em,qm),  mk(f,0,em,qm),  "R4 qnan/qnan");
      run(f, mk(f,0,em,qm),  mk(f,0,bias,0), "R4 qnan/num");
      run(f, mk(f,0,bias,0), mk(f,1,em,qm|3), "R4 num/qnan");
      run(f, mk(f,0,em,sm),  mk(f,0,bias,0), "R5 snan/num");
      run(f, mk(f,0,bias,0), mk(f,1,em,sm),  "R5 num/snan");
      run(f, mk(f,0,em,sm),  mk(f,0,em,qm),  "R5 snan/qnan");
      run(f, mk(f,0,em,qm),  mk(f,0,em,sm),  "R5 qnan/snan");
      run(f, mk(f,1,em,sm),  mk(f,1,em,sm),  "R5 snan/snan");
      run(f, mk(f,0,em,qm-1), mk(f,0,em,0),  "R6 snan/inf");
      run(f, mk(f,0,em,qm),  mk(f,0,em,0),   "R3 qnan/inf");
      if (f < 2) begin
        int w = 1 + ew + mw;
        run(f, mk(f,0,bias,0) | (64'hdead_beef_cafe_f00d << w),
               mk(f,0,bias,0) | (64'h1234_5678_9abc_def0 << w), "R2 upper garbage eq");
        run(f, mk(f,0,0,0) | (64'h1 << w), mk(f,1,0,0), "R2 upper garbage zero");
        run(f, mk(f,0,bias,0) | (64'hffff_ffff_ffff_ffff << w),
               mk(f,0,bias,0), "R2 upper ones");
        run(f, mk(f,0,em,sm) | (64'hffff_ffff_ffff_ffff << w),
               mk(f,0,em,sm), "R2 upper on snan");
      end
    end

    // reserved code behaves as double
    run(3, mk(2,0,1023,0), mk(2,0,1023,0), "R1 rsvd eq");
    run(3, mk(2,0,2047,1), mk(2,0,1023,0), "R1 rsvd snan");
    run(3, 64'h0000_0000_0000_3c00, 64'h0000_0000_0000_3c00, "R1 rsvd as double");
    run(3, 64'h8000_0000_0000_0000, 64'h0, "R1 rsvd zero");

    // random stream, often with b = a (R11: fresh inputs each cycle)
    for (int i = 0; i < 600; i++) begin
      int f = int'($urandom_range(0, 3));
      logic [63:0] a = {$urandom(), $urandom()};
      logic [63:0] b = ($urandom_range(0, 2) == 0) ? a : {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) a[62:52] = 11'h7ff;
      if ($urandom_range(0, 3) == 0) b[30:23] = 8'hff;
      if ($urandom_range(0, 3) == 0) a[14:10] = 5'h1f;
      run(f, a, b, "R11 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule